// File: doc/BRIEF.md
# Multicart Outer Bank Combiner

This block sits between the bank controller of a game cartridge and the ROM of a multi-game cartridge. The bank controller emulates one of three schemes and produces raw bank numbers for four 8 KiB program windows and eight 1 KiB pattern windows. The combiner confines those numbers to one slice of the large ROM. Each physical bank is built as (inner AND mask) OR (outer AND NOT mask). The outer value and the mask size come from three configuration registers. The CPU writes these registers in the 0x5000–0x5FFF range. A read anywhere in that range returns a switch counter that advances on every soft reset. Menu software uses this counter to choose a game.

Layout bits can bypass the bank controller completely. They fix program space as one mirrored 16 KiB bank or as one 32 KiB bank, and they fix pattern space as one 8 KiB bank. The combiner also tells the controller which scheme is active. All bank outputs are combinational from the registers, so a register write shows on the outputs in the cycle after the write edge.

Top module: `outer_bank_combiner`

## Requirements
- R1: A write is taken when `cpu_we` is high and `cpu_addr[15:12]` is 0x5. `cpu_addr[1:0]` then selects the pattern-base register (0), the program-base register (1) or the layout register (2). A write at offset 3 changes nothing. A write outside 0x5000–0x5FFF changes nothing. Registers change at the clock edge that samples the write.
- R2: `cpu_rdata` is the switch counter whenever `cpu_addr[15:12]` is 0x5, and 0 otherwise.
- R3: A low `rst_n` clears all registers and the switch counter. A high `soft_rst` at an edge clears all registers and adds one to the counter (modulo 256). If a write arrives in the same cycle, `soft_rst` takes priority and the write is lost.
- R4: The program mask is 0x0F when layout bit 2 is set and 0x1F when it is clear. The program outer value is the program-base register shifted right by one. Each window is (inner AND mask) OR (outer AND NOT mask), with 8 bits in 8 KiB units.
- R5: In the 8 KiB-window scheme and in the nibble scheme, window 1 uses `inner_prg` window 1 and window 3 uses 0xFF. With `inner_prg_swap` low, window 0 uses inner window 0 and window 2 uses 0xFE. With `inner_prg_swap` high, those two swap.
- R6: In the serial scheme, each `inner_prg` window carries a 16 KiB bank number. Window k outputs ((inner AND mask>>1) OR ((outer>>1) AND NOT (mask>>1))) times 2, plus k bit 0.
- R7: When layout bit 7 is set, program space is fixed and ignores the inner banks. With layout bit 2 set, window k = (outer AND 0x7E) + (k mod 2). With layout bit 2 clear, window k = (outer AND 0x7C) + k.
- R8: The pattern mask is 0x1F if layout bit 4 is set, else 0x7F if layout bit 5 is set, else 0xFF. The pattern outer value is the pattern-base register shifted left by one. Each 9-bit window in 1 KiB units is (inner AND mask) OR (outer AND NOT mask).
- R9: In the serial scheme, each `inner_chr` window carries a 4 KiB bank number. Window k outputs ((inner AND mask>>2) OR ((outer>>2) AND NOT (mask>>2))) times 4, plus k mod 4.
- R10: When layout bit 6 is set, pattern window k = (outer AND 0x1F8) + k, whatever the inner banks are.
- R11: Pattern-base bits [1:0] select the scheme, and `inner_sel` reports it. Bit 1 clear gives 00 (8 KiB-window scheme). 11 gives 10 (nibble scheme). 10 gives 01 (serial scheme). `inner_sel` never reads 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| soft_rst | input | 1 | Console reset, synchronous, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Switch counter when 0x5xxx is addressed, else 0 |
| inner_prg | input | 32 | Inner program banks, window k at bits [8k+7:8k] |
| inner_prg_swap | input | 1 | Window 0/2 swap from the bank controller |
| inner_chr | input | 64 | Inner pattern banks, window k at bits [8k+7:8k] |
| prg_bank | output | 32 | Physical 8 KiB program banks, window k at [8k+7:8k] |
| chr_bank | output | 72 | Physical 1 KiB pattern banks, window k at [9k+8:9k] |
| inner_sel | output | 2 | Active scheme code |

## Verification
A soft reset and a register write can fall in the same cycle. The soft reset must win: the registers stay cleared and the counter still advances. The bench drives both in one cycle and then checks every window against the all-zero layout and the read value against the new count. The scheme change (R11) and the layout change (R7) also take effect in one cycle. Random writes cover this by switching the scheme bits and the fixed-layout bits against random inner banks. The bench model then judges all twelve windows after every write.

// File: rtl/obc_pkg.sv
package obc_pkg;
    localparam int NPRG   = 4;
    localparam int NCHR   = 8;
    localparam int IB_W   = 8;
    localparam int PRG_W  = 8;
    localparam int CHR_W  = 9;
    localparam int DIP_W  = 8;
    localparam int PB_W   = 7;

    localparam logic [PB_W-1:0]  PRG_MASK_WIDE   = 7'h1F;
    localparam logic [PB_W-1:0]  PRG_MASK_NARROW = 7'h0F;
    localparam logic [CHR_W-1:0] CHR_MASK_FULL   = 9'h0FF;
    localparam logic [CHR_W-1:0] CHR_MASK_128    = 9'h07F;
    localparam logic [CHR_W-1:0] CHR_MASK_32     = 9'h01F;

    typedef enum logic [1:0] {
        SCH_WIN = 2'b00,
        SCH_SER = 2'b01,
        SCH_NIB = 2'b10
    } scheme_e;

    typedef struct packed {
        logic [7:0]      chr_base;
        logic [PB_W-1:0] prg_base;
        logic            prg_fix;
        logic            chr_fix;
        logic            chr_128;
        logic            chr_32;
        logic            prg_narrow;
        logic [DIP_W-1:0] dip;
    } cfg_t;

    function automatic scheme_e decode_scheme(input logic [1:0] sel);
        if (!sel[1])    return SCH_WIN;
        else if (sel[0]) return SCH_NIB;
        else            return SCH_SER;
    endfunction
endpackage

// File: rtl/obc_cfg_regs.sv
module obc_cfg_regs
    import obc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_we,
    input  logic [7:0]  cpu_wdata,
    output cfg_t        cfg
);
    cfg_t cfg_d, cfg_q;
    logic hit;
    logic unused_addr_mid;

    assign hit             = cpu_we && (cpu_addr[15:12] == 4'h5);
    assign unused_addr_mid = ^cpu_addr[11:2];

    always_comb begin
        cfg_d = cfg_q;
        if (soft_rst) begin
            cfg_d     = '0;
            cfg_d.dip = cfg_q.dip + 1'b1;
        end else if (hit) begin
            case (cpu_addr[1:0])
                2'd0: cfg_d.chr_base = cpu_wdata;
                2'd1: cfg_d.prg_base = cpu_wdata[7:1];
                2'd2: begin
                    cfg_d.prg_fix    = cpu_wdata[7];
                    cfg_d.chr_fix    = cpu_wdata[6];
                    cfg_d.chr_128    = cpu_wdata[5];
                    cfg_d.chr_32     = cpu_wdata[4];
                    cfg_d.prg_narrow = cpu_wdata[2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/obc_prg_map.sv
module obc_prg_map
    import obc_pkg::*;
(
    input  logic [PB_W-1:0]      prg_base,
    input  logic                 prg_fix,
    input  logic                 prg_narrow,
    input  scheme_e              scheme,
    input  logic                 swap,
    input  logic [NPRG*IB_W-1:0] inner,
    output logic [NPRG*PRG_W-1:0] bank
);
    logic [PB_W-1:0]  mask7;
    logic [PRG_W-1:0] mask8, outer8, mask_ser, outer_ser;

    assign mask7     = prg_narrow ? PRG_MASK_NARROW : PRG_MASK_WIDE;
    assign mask8     = {1'b0, mask7};
    assign outer8    = {1'b0, prg_base};
    assign mask_ser  = mask8 >> 1;
    assign outer_ser = outer8 >> 1;

    for (genvar k = 0; k < NPRG; k++) begin : g_win
        localparam logic [2:0] KB = 3'(k);
        logic [IB_W-1:0]  raw;
        logic [IB_W-1:0]  pick;
        logic [PRG_W-1:0] out_w;

        assign raw = inner[k*IB_W +: IB_W];

        always_comb begin
            if (k == 1)      pick = raw;
            else if (k == 3) pick = 8'hFF;
            else if ((k == 0) != swap) pick = inner[0 +: IB_W];
            else             pick = 8'hFE;
        end

        always_comb begin
            if (prg_fix) begin
                if (prg_narrow) out_w = {1'b0, prg_base[PB_W-1:1], KB[0]};
                else            out_w = {1'b0, prg_base[PB_W-1:2], KB[1:0]};
            end else if (scheme == SCH_SER) begin
                out_w = (((raw & mask_ser) | (outer_ser & ~mask_ser)) << 1)
                        | {7'b0, KB[0]};
            end else begin
                out_w = (pick & mask8) | (outer8 & ~mask8);
            end
        end

        assign bank[k*PRG_W +: PRG_W] = out_w;
    end
endmodule

// File: rtl/obc_chr_map.sv
module obc_chr_map
    import obc_pkg::*;
(
    input  logic [7:0]            chr_base,
    input  logic                  chr_fix,
    input  logic                  chr_128,
    input  logic                  chr_32,
    input  scheme_e               scheme,
    input  logic [NCHR*IB_W-1:0]  inner,
    output logic [NCHR*CHR_W-1:0] bank
);
    logic [CHR_W-1:0] mask9, outer9, mask_ser, outer_ser;

    assign mask9     = chr_32 ? CHR_MASK_32 : (chr_128 ? CHR_MASK_128 : CHR_MASK_FULL);
    assign outer9    = {chr_base, 1'b0};
    assign mask_ser  = mask9 >> 2;
    assign outer_ser = outer9 >> 2;

    for (genvar k = 0; k < NCHR; k++) begin : g_win
        localparam logic [2:0] KB = 3'(k);
        logic [CHR_W-1:0] raw9;
        logic [CHR_W-1:0] out_w;

        assign raw9 = {1'b0, inner[k*IB_W +: IB_W]};

        always_comb begin
            if (chr_fix)
                out_w = {chr_base[7:2], KB};
            else if (scheme == SCH_SER)
                out_w = (((raw9 & mask_ser) | (outer_ser & ~mask_ser)) << 2)
                        | {7'b0, KB[1:0]};
            else
                out_w = (raw9 & mask9) | (outer9 & ~mask9);
        end

        assign bank[k*CHR_W +: CHR_W] = out_w;
    end
endmodule

// File: rtl/outer_bank_combiner.sv
module outer_bank_combiner
    import obc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_we,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    input  logic [31:0] inner_prg,
    input  logic        inner_prg_swap,
    input  logic [63:0] inner_chr,
    output logic [31:0] prg_bank,
    output logic [71:0] chr_bank,
    output logic [1:0]  inner_sel
);
    cfg_t    cfg;
    scheme_e scheme;
    logic [7:0]      chr_base_w;
    logic [PB_W-1:0] prg_base_w;
    logic [4:0]      layout_w;
    logic [DIP_W-1:0] dip_w;

    obc_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .cpu_addr  (cpu_addr),
        .cpu_we    (cpu_we),
        .cpu_wdata (cpu_wdata),
        .cfg       (cfg)
    );

    assign chr_base_w = cfg.chr_base;
    assign prg_base_w = cfg.prg_base;
    assign layout_w   = {cfg.prg_fix, cfg.chr_fix, cfg.chr_128, cfg.chr_32, cfg.prg_narrow};
    assign dip_w      = cfg.dip;
    assign scheme     = decode_scheme(chr_base_w[1:0]);

    obc_prg_map u_prg (
        .prg_base   (prg_base_w),
        .prg_fix    (layout_w[4]),
        .prg_narrow (layout_w[0]),
        .scheme     (scheme),
        .swap       (inner_prg_swap),
        .inner      (inner_prg),
        .bank       (prg_bank)
    );

    obc_chr_map u_chr (
        .chr_base (chr_base_w),
        .chr_fix  (layout_w[3]),
        .chr_128  (layout_w[2]),
        .chr_32   (layout_w[1]),
        .scheme   (scheme),
        .inner    (inner_chr),
        .bank     (chr_bank)
    );

    assign inner_sel = scheme;
    assign cpu_rdata = (cpu_addr[15:12] == 4'h5) ? dip_w : 8'h00;
endmodule

// File: rtl/outer_bank_combiner_chk.sv
module outer_bank_combiner_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        cpu_we,
    input logic [15:0] cpu_addr,
    input logic [7:0]  chr_base,
    input logic [6:0]  prg_base,
    input logic [4:0]  layout,
    input logic [7:0]  dip,
    input logic [31:0] prg_bank,
    input logic [71:0] chr_bank,
    input logic [1:0]  inner_sel
);
    logic [6:0] pmask;
    assign pmask = layout[0] ? 7'h0F : 7'h1F;

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !(cpu_we && cpu_addr[15:12] == 4'h5)) |=> $stable({chr_base, prg_base, layout})); // R1
    AST_SOFT_DIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> dip == $past(dip) + 8'd1); // R3
    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (chr_base == 8'h00 && prg_base == 7'h00 && layout == 5'h00)); // R3
    AST_LAST_WIN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!layout[4] && inner_sel != 2'b01) |-> ((prg_bank[31:24] & {1'b0, pmask}) == {1'b0, pmask})); // R5
    AST_PRG_FIX32: assert property (@(posedge clk) disable iff (!rst_n)
        (layout[4] && !layout[0]) |-> (prg_bank[1:0] == 2'd0 && prg_bank[15:8] == prg_bank[7:0] + 8'd1
            && prg_bank[31:24] == prg_bank[7:0] + 8'd3)); // R7
    AST_PRG_FIX16: assert property (@(posedge clk) disable iff (!rst_n)
        (layout[4] && layout[0]) |-> (prg_bank[23:16] == prg_bank[7:0] && prg_bank[31:24] == prg_bank[15:8])); // R7
    AST_CHR_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        layout[3] |-> (chr_bank[2:0] == 3'd0 && chr_bank[71:63] == chr_bank[8:0] + 9'd7)); // R10
    AST_SEL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        inner_sel != 2'b11); // R11
endmodule

bind outer_bank_combiner outer_bank_combiner_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .chr_base  (chr_base_w),
    .prg_base  (prg_base_w),
    .layout    (layout_w),
    .dip       (dip_w),
    .prg_bank  (prg_bank),
    .chr_bank  (chr_bank),
    .inner_sel (inner_sel)
);

// File: tb/outer_bank_combiner_tb.sv
`timescale 1ns/1ps
module outer_bank_combiner_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic [31:0] inner_prg = 32'h0;
    logic        inner_prg_swap = 1'b0;
    logic [63:0] inner_chr = 64'h0;
    logic [31:0] prg_bank;
    logic [71:0] chr_bank;
    logic [1:0]  inner_sel;

    int n_chk = 0;
    int n_bad = 0;
    int m0 = 0, m1 = 0, m2 = 0, mdip = 0;

    always #2.5 clk = ~clk;

    outer_bank_combiner u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .inner_prg(inner_prg),
        .inner_prg_swap(inner_prg_swap), .inner_chr(inner_chr),
        .prg_bank(prg_bank), .chr_bank(chr_bank), .inner_sel(inner_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int ip(int k); return int'(inner_prg[8*k +: 8]); endfunction
    function automatic int ic(int k); return int'(inner_chr[8*k +: 8]); endfunction
    function automatic bit serial_mode(); return (m0 & 3) == 2; endfunction

    function automatic int e_prg(int k);
        int pm, po, v;
        pm = (m2 & 'h04) ? 'h0F : 'h1F;
        po = m1 >> 1;
        if (m2 & 'h80) begin
            if (m2 & 'h04) return ((po >> 1) << 1) | (k & 1);
            return ((po >> 2) << 2) | k;
        end
        if (serial_mode())
            return ((((ip(k) & (pm >> 1)) | ((po >> 1) & ~(pm >> 1))) & 'h7F) << 1) | (k & 1);
        if (k == 1) v = ip(1);
        else if (k == 3) v = 'hFF;
        else if ((k == 0) != inner_prg_swap) v = ip(0);
        else v = 'hFE;
        return ((v & pm) | (po & ~pm)) & 'hFF;
    endfunction

    function automatic int e_chr(int k);
        int cm, co;
        cm = (m2 & 'h10) ? 'h1F : ((m2 & 'h20) ? 'h7F : 'hFF);
        co = m0 << 1;
        if (m2 & 'h40) return ((co >> 3) << 3) | k;
        if (serial_mode())
            return ((((ic(k) & (cm >> 2)) | ((co >> 2) & ~(cm >> 2))) & 'h7F) << 2) | (k & 3);
        return ((ic(k) & cm) | (co & ~cm)) & 'h1FF;
    endfunction

    function automatic string prg_tag(int k);
        if (m2 & 'h80) return "R7 fixed prg";
        if (serial_mode()) return "R6 serial prg";
        if (k >= 2 || inner_prg_swap) return "R5 fixed tail/swap";
        return "R4 prg merge";
    endfunction

    function automatic string chr_tag();
        if (m2 & 'h40) return "R10 fixed chr";
        if (serial_mode()) return "R9 serial chr";
        return "R8 chr merge";
    endfunction

    task automatic check_all();
        int es;
        for (int k = 0; k < 4; k++) chk(prg_tag(k), int'(prg_bank[8*k +: 8]), e_prg(k));
        for (int k = 0; k < 8; k++) chk(chr_tag(), int'(chr_bank[9*k +: 9]), e_chr(k));
        es = ((m0 & 2) == 0) ? 0 : ((m0 & 1) ? 2 : 1);
        chk("R11 scheme code", int'(inner_sel), es);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input bit with_soft);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1; soft_rst = with_soft;
        @(negedge clk);
        cpu_we = 1'b0; soft_rst = 1'b0; cpu_addr = 16'h8000;
        if (with_soft) begin
            m0 = 0; m1 = 0; m2 = 0; mdip = (mdip + 1) & 'hFF;
        end else if (a[15:12] == 4'h5) begin
            case (a[1:0])
                2'd0: m0 = d;
                2'd1: m1 = d;
                2'd2: m2 = d;
                default: ;
            endcase
        end
    endtask

    task automatic new_inner();
        inner_prg = {$urandom, $urandom} [31:0];
        inner_chr = {$urandom, $urandom};
        inner_prg_swap = 1'($urandom);
        #0.5;
    endtask

    task automatic check_read();
        cpu_addr = 16'h5000 | 16'($urandom & 'hFFF);
        #0.5 chk("R2 read in range", int'(cpu_rdata), mdip);
        cpu_addr = 16'h6000;
        #0.5 chk("R2 read out of range", int'(cpu_rdata), 0);
        cpu_addr = 16'h8000;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] snap_p;
        logic [71:0] snap_c;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 power-on state
        chk("R3 power-on dip", int'(cpu_rdata), 0);
        inner_prg = 32'hA5C3_7E19; inner_chr = 64'h0123_4567_89AB_CDEF; #0.5;
        check_all();
        check_read();

        // R1 writes outside range or at offset 3 are ignored
        do_write(16'h5001, 8'hB6, 1'b0);
        do_write(16'h5002, 8'h24, 1'b0);
        snap_p = prg_bank; snap_c = chr_bank;
        do_write(16'h5003, 8'hFF, 1'b0);
        chk("R1 offset3 prg", int'(prg_bank), int'(snap_p));
        chk("R1 offset3 chr", int'(chr_bank[31:0]), int'(snap_c[31:0]));
        do_write(16'h6002, 8'hC0, 1'b0);
        do_write(16'h4000, 8'hFF, 1'b0);
        chk("R1 out of range prg", int'(prg_bank), int'(snap_p));
        check_all();

        // R7 fixed 16/32 KiB, R10 fixed pattern bank
        do_write(16'h5002, 8'hC4, 1'b0); check_all();
        do_write(16'h5002, 8'hC0, 1'b0); check_all();
        // R6/R9 serial scheme, R11 code
        do_write(16'h5000, 8'h6A, 1'b0);
        do_write(16'h5002, 8'h10, 1'b0); new_inner(); check_all();
        // R5 swap both ways in nibble scheme
        do_write(16'h5000, 8'h93, 1'b0);
        inner_prg_swap = 1'b1; #0.5 check_all();
        inner_prg_swap = 1'b0; #0.5 check_all();

        // R3 soft reset beats a same-cycle write; counter steps
        do_write(16'h5002, 8'hFF, 1'b1);
        check_all();
        chk("R3 soft reset clears layout", int'(inner_sel), 0);
        check_read();
        do_write(16'h5000, 8'h00, 1'b1);
        check_read();

        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 4)
                do_write(16'h5000 | 16'($urandom & 3), 8'($urandom), 1'b1);
            else if (r < 85)
                do_write(16'h5000 | 16'($urandom & 'hFFF), 8'($urandom), 1'b0);
            else
                do_write(16'($urandom), 8'($urandom), 1'b0);
            new_inner();
            check_all();
            if (i % 50 == 0) check_read();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule